// File: doc/BRIEF.md
# Reset Source Sequencer and Classifier

This block merges every reset request of a small controller into one internal reset and decides which reset vector the processor fetches when it leaves reset. It accepts three internal request lines (power-on detector, watchdog timeout, clock-loss detector) and the level of the bidirectional reset pin. The pin is driven open-drain: the block only ever pulls it low, and an external resistor or an external device sets the level otherwise.

Any internal request asserts the internal reset at once, with no clock edge needed, and pulls the pin low. Once the last request has gone away, the block keeps the pin low for a fixed number of clock cycles and then lets it go. A fixed number of cycles later it looks at the synchronized pin. If the pin has risen, the reset was internal and the vector names the internal cause. If the pin is still low, some outside device is holding it, and the reset is treated as external. An external device that pulls the pin low while the chip is running starts the same sequence. The internal reset is released through a synchronizer on the clock, so leaving reset needs a running clock.

Top module: `rstCtrlTop`

## Requirements
- R1: Any of `porReq`, `copReq` or `cmonReq` asserts `sysReset` and `pinPullDown` with no clock edge. A low `pinLevel` asserts `sysReset` with no clock edge.
- R2: After the last internal request deasserts, `pinPullDown` stays high for exactly DRIVE_CYC clock cycles and then falls.
- R3: The pin is read through a SYNC_STAGES-flop synchronizer, SAMPLE_CYC cycles after the pull-down is released. The reset counts as external when the pin was low at clock edge DRIVE_CYC+SAMPLE_CYC-SYNC_STAGES after the last request drop, and as internal when it was high.
- R4: On an internal classification, `sysReset` falls DRIVE_CYC+SAMPLE_CYC+SYNC_STAGES cycles after the last request drop.
- R5: On an external classification, `sysReset` stays high while the pin is low. It falls 1+2*SYNC_STAGES cycles after the pin rises.
- R6: `vecSel` encodes the vector: 2'b00 normal, 2'b01 clock loss, 2'b10 watchdog, and never 2'b11. Among internal causes latched since the previous classification, power-on wins over clock loss, and clock loss wins over watchdog.
- R7: An external classification selects 2'b00 whatever internal causes are latched.
- R8: A low pin while out of reset starts the full drive, release and sample sequence. A pulse that has ended before the sample classifies as internal with vector 2'b00.
- R9: A new internal request during a running sequence restarts it from the beginning. Causes latched earlier are kept for the classification.
- R10: `vecSel` changes only while `sysReset` is high. `sysReset` never falls while the pin is low or being pulled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that paces the sequence |
| porReq | input | 1 | Power-on request from the supply detector, active high, asynchronous |
| copReq | input | 1 | Watchdog timeout request, active high, asynchronous |
| cmonReq | input | 1 | Clock-loss request, active high, asynchronous |
| pinLevel | input | 1 | Raw level read back from the reset pin |
| pinPullDown | output | 1 | Enables the open-drain pull-down on the reset pin |
| sysReset | output | 1 | Internal reset to the rest of the chip, active high |
| vecSel | output | 2 | Reset vector select, valid when sysReset falls |

## Verification
The bench builds the block with DRIVE_CYC=16, SAMPLE_CYC=8 and SYNC_STAGES=2. With these values one sequence lasts under thirty cycles, so the bench can run every non-empty mix of internal causes against no external hold and against an external hold that ends one cycle before or on the sample boundary. It also runs short and long external pulses starting from normal operation, and a request that arrives during the wait phase. Every expected duration and vector comes from the formulas in the requirements.

// File: rtl/rstSeqPkg.sv
package rstSeqPkg;

  typedef enum logic [1:0] {
    VEC_NORMAL = 2'b00,
    VEC_CMON   = 2'b01,
    VEC_COP    = 2'b10
  } vecSel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DRIVE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_HOLD  = 2'd3
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic drive;     // pull the pin low
    logic busy;      // sequence in progress, keep reset requested
    logic sample;    // classification edge
    logic extFound;  // pin seen low at classification edge
  } ctlStrobe_t;

endpackage

// File: rtl/syncChain.sv
module syncChain #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic asyncSet,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage;

  always_ff @(posedge clk or posedge asyncSet) begin
    if (asyncSet) begin
      stage <= '1;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stage[i] <= stage[i-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/rstSeqCtrl.sv
module rstSeqCtrl
  import rstSeqPkg::*;
#(
  parameter int DRIVE_CYC  = 16,
  parameter int SAMPLE_CYC = 8
) (
  input  logic       clk,
  input  logic       intReq,
  input  logic       pinSync,
  output ctlStrobe_t strb
);
  localparam int MAX_CYC = (DRIVE_CYC > SAMPLE_CYC) ? DRIVE_CYC : SAMPLE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC) + 1;
  localparam logic [CNT_W-1:0] DRIVE_LAST  = CNT_W'(DRIVE_CYC - 1);
  localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_CYC - 1);

  seqState_e        state;
  logic [CNT_W-1:0] cnt;

  // entry is asynchronous: any internal request parks the sequence at the
  // start of the drive phase for as long as it is held
  always_ff @(posedge clk or posedge intReq) begin
    if (intReq) begin
      state <= ST_DRIVE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (!pinSync) begin
            state <= ST_DRIVE;
            cnt   <= '0;
          end
        end
        ST_DRIVE: begin
          if (cnt == DRIVE_LAST) begin
            state <= ST_WAIT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (cnt == SAMPLE_LAST) begin
            state <= pinSync ? ST_IDLE : ST_HOLD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (pinSync) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.drive    = (state == ST_DRIVE);
    strb.busy     = (state != ST_IDLE);
    strb.sample   = (state == ST_WAIT) && (cnt == SAMPLE_LAST);
    strb.extFound = strb.sample && !pinSync;
  end
endmodule

// File: rtl/rstSeqDatapath.sv
module rstSeqDatapath
  import rstSeqPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porReq,
  input  logic       copReq,
  input  logic       cmonReq,
  input  logic       pinLevel,
  input  ctlStrobe_t strb,
  output logic       pinSync,
  output logic       pinPullDown,
  output logic       sysReset,
  output logic [1:0] vecSel
);
  logic    intReq;
  logic    relSet;
  logic    porSeen, copSeen, cmonSeen;
  vecSel_e vecNext;
  vecSel_e vecReg;

  assign intReq = porReq | copReq | cmonReq;
  assign relSet = intReq | ~pinLevel;

  // pin level into the clock domain
  syncChain #(.STAGES(SYNC_STAGES)) pinSync_i (
    .clk     (clk),
    .asyncSet(porReq),
    .d       (pinLevel),
    .q       (pinSync)
  );

  // reset release: set at once, cleared only through the chain
  syncChain #(.STAGES(SYNC_STAGES)) relSync_i (
    .clk     (clk),
    .asyncSet(relSet),
    .d       (strb.busy),
    .q       (sysReset)
  );

  // cause flags latch asynchronously and clear at classification
  always_ff @(posedge clk or posedge porReq) begin
    if (porReq)           porSeen <= 1'b1;
    else if (strb.sample) porSeen <= 1'b0;
  end

  always_ff @(posedge clk or posedge copReq) begin
    if (copReq)           copSeen <= 1'b1;
    else if (strb.sample) copSeen <= 1'b0;
  end

  always_ff @(posedge clk or posedge cmonReq) begin
    if (cmonReq)          cmonSeen <= 1'b1;
    else if (strb.sample) cmonSeen <= 1'b0;
  end

  always_comb begin
    if (strb.extFound)  vecNext = VEC_NORMAL;
    else if (porSeen)   vecNext = VEC_NORMAL;
    else if (cmonSeen)  vecNext = VEC_CMON;
    else if (copSeen)   vecNext = VEC_COP;
    else                vecNext = VEC_NORMAL;
  end

  always_ff @(posedge clk or posedge porReq) begin
    if (porReq)           vecReg <= VEC_NORMAL;
    else if (strb.sample) vecReg <= vecNext;
  end

  assign vecSel      = vecReg;
  assign pinPullDown = strb.drive;
endmodule

// File: rtl/rstCtrlTop.sv
module rstCtrlTop
  import rstSeqPkg::*;
#(
  parameter int DRIVE_CYC   = 16,
  parameter int SAMPLE_CYC  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porReq,
  input  logic       copReq,
  input  logic       cmonReq,
  input  logic       pinLevel,
  output logic       pinPullDown,
  output logic       sysReset,
  output logic [1:0] vecSel
);
  ctlStrobe_t strb;
  logic       pinSync;
  logic       intReq;

  assign intReq = porReq | copReq | cmonReq;

  rstSeqCtrl #(
    .DRIVE_CYC (DRIVE_CYC),
    .SAMPLE_CYC(SAMPLE_CYC)
  ) ctrl_i (
    .clk    (clk),
    .intReq (intReq),
    .pinSync(pinSync),
    .strb   (strb)
  );

  rstSeqDatapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk        (clk),
    .porReq     (porReq),
    .copReq     (copReq),
    .cmonReq    (cmonReq),
    .pinLevel   (pinLevel),
    .strb       (strb),
    .pinSync    (pinSync),
    .pinPullDown(pinPullDown),
    .sysReset   (sysReset),
    .vecSel     (vecSel)
  );
endmodule

// File: rtl/rstCtrlChecker.sv
module rstCtrlChecker #(
  parameter int DRIVE_CYC = 16
) (
  input logic       clk,
  input logic       porReq,
  input logic       copReq,
  input logic       cmonReq,
  input logic       pinLevel,
  input logic       pinPullDown,
  input logic       sysReset,
  input logic [1:0] vecSel
);
  localparam int RUN_W = $clog2(DRIVE_CYC + 2) + 1;

  logic             anyReq;
  logic [RUN_W-1:0] pdRun;

  assign anyReq = porReq | copReq | cmonReq;

  // length of the current pull-down stretch with no request present
  always_ff @(posedge clk or posedge anyReq) begin
    if (anyReq)           pdRun <= '0;
    else if (pinPullDown) pdRun <= pdRun + 1'b1;
    else                  pdRun <= '0;
  end

  a_r1_pulldown_in_reset: assert property (@(posedge clk) disable iff (porReq)
    pinPullDown |-> sysReset);

  a_r2_pulldown_len: assert property (@(posedge clk) disable iff (anyReq)
    pdRun <= RUN_W'(DRIVE_CYC));

  a_r10_release_pin_high: assert property (@(posedge clk) disable iff (anyReq)
    $fell(sysReset) |-> ($past(pinLevel) && !$past(pinPullDown)));

  a_r10_vec_moves_in_reset: assert property (@(posedge clk) disable iff (anyReq)
    !$stable(vecSel) |-> sysReset);

  a_r6_vec_legal: assert property (@(posedge clk) disable iff (porReq)
    vecSel != 2'b11);

  a_r5_hold_while_low: assert property (@(posedge clk) disable iff (anyReq)
    (!pinLevel && !$past(pinLevel)) |-> sysReset);
endmodule

bind rstCtrlTop rstCtrlChecker #(.DRIVE_CYC(DRIVE_CYC)) chk_i (
  .clk        (clk),
  .porReq     (porReq),
  .copReq     (copReq),
  .cmonReq    (cmonReq),
  .pinLevel   (pinLevel),
  .pinPullDown(pinPullDown),
  .sysReset   (sysReset),
  .vecSel     (vecSel)
);

// File: tb/rstCtrlTop_tb_top.sv
module rstCtrlTop_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DRV = 16;
  localparam int SMP = 8;
  localparam int SYN = 2;
  localparam int BOUND = DRV + SMP - SYN;  // last edge at which the pin is read

  logic clk = 1'b0;
  logic porReq = 1'b1;
  logic copReq = 1'b0;
  logic cmonReq = 1'b0;
  logic extHold = 1'b0;
  logic pinLevel;
  logic pinPullDown;
  logic sysReset;
  logic [1:0] vecSel;

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // open-drain pin: low if either side pulls
  assign pinLevel = !(pinPullDown || extHold);

  rstCtrlTop #(.DRIVE_CYC(DRV), .SAMPLE_CYC(SMP), .SYNC_STAGES(SYN)) dut_i (
    .clk        (clk),
    .porReq     (porReq),
    .copReq     (copReq),
    .cmonReq    (cmonReq),
    .pinLevel   (pinLevel),
    .pinPullDown(pinPullDown),
    .sysReset   (sysReset),
    .vecSel     (vecSel)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count cycles of reset and pull-down from the current negedge on;
  // extRel >= 0 releases the external hold at the negedge after edge extRel
  task automatic measure(input int extRel, output int hi, output int pd);
    bit done = 1'b0;
    hi = 0;
    pd = 0;
    for (int k = 1; k <= 400 && !done; k++) begin
      if (k > 1) @(negedge clk);
      if (extRel >= 0 && k == extRel + 1) extHold = 1'b0;
      #1;
      if (pinPullDown) pd++;
      if (sysReset) hi++;
      else done = 1'b1;
    end
  endtask

  task automatic checkIdle(input string req);
    repeat (4) @(negedge clk);
    #1;
    chk(sysReset == 1'b0 && pinPullDown == 1'b0, req, {sysReset, pinPullDown}, 0);
  endtask

  function automatic int expVec(input bit p, input bit m, input bit c, input bit ext);
    if (ext) return 0;
    if (p) return 0;
    if (m) return 1;
    if (c) return 2;
    return 0;
  endfunction

  // internal request mix, optional external hold released after extD edges
  task automatic runCase(input bit p, input bit m, input bit c, input int extD);
    int hi, pd, eHi;
    bit isExt;
    @(negedge clk);
    porReq = p; cmonReq = m; copReq = c;
    if (extD >= 0) extHold = 1'b1;
    #1;
    chk(sysReset && pinPullDown, "R1 async entry", {sysReset, pinPullDown}, 3);
    repeat (3) @(negedge clk);
    porReq = 1'b0; cmonReq = 1'b0; copReq = 1'b0;
    measure(extD, hi, pd);
    isExt = (extD >= BOUND);
    eHi = isExt ? (extD + 1 + 2 * SYN) : (DRV + SMP + SYN);
    chk(pd == DRV, "R2 pull-down length", pd, DRV);
    if (isExt) chk(hi == eHi, "R5 external release timing", hi, eHi);
    else       chk(hi == eHi, "R4 internal release timing", hi, eHi);
    if (isExt) chk(int'(vecSel) == 0, "R7 external override vector", vecSel, 0);
    else       chk(int'(vecSel) == expVec(p, m, c, 1'b0), "R6 cause vector",
                   vecSel, expVec(p, m, c, 1'b0));
    checkIdle("R3 stays out of reset");
  endtask

  initial begin
    int hi, pd;
    #1;
    chk(sysReset && pinPullDown, "R1 reset state", {sysReset, pinPullDown}, 3);
    chk(int'(vecSel) == 0, "R6 reset vector", vecSel, 0);

    // power-on release from time zero
    @(negedge clk);
    porReq = 1'b0;
    measure(-1, hi, pd);
    chk(pd == DRV, "R2 power-on pull-down", pd, DRV);
    chk(hi == DRV + SMP + SYN, "R4 power-on release", hi, DRV + SMP + SYN);
    chk(int'(vecSel) == 0, "R6 power-on vector", vecSel, 0);
    checkIdle("R4 idle after power-on");

    // all cause mixes, no hold / hold ending just before / on the boundary
    for (int mix = 1; mix < 8; mix++) begin
      runCase(mix[2], mix[1], mix[0], -1);
      runCase(mix[2], mix[1], mix[0], BOUND - 1);
      runCase(mix[2], mix[1], mix[0], BOUND);
    end
    runCase(1'b0, 1'b0, 1'b1, BOUND + 9);
    runCase(1'b0, 1'b1, 1'b0, BOUND + 30);

    // R8: long external pulse while running
    @(negedge clk);
    extHold = 1'b1;
    #1;
    chk(sysReset == 1'b1 && pinPullDown == 1'b0, "R1 pin entry async", {sysReset, pinPullDown}, 2);
    repeat (40) @(negedge clk);
    measure(0, hi, pd);
    chk(hi == 1 + 2 * SYN, "R5 long pulse release", hi, 1 + 2 * SYN);
    chk(int'(vecSel) == 0, "R8 long pulse vector", vecSel, 0);
    checkIdle("R8 idle after long pulse");

    // R8: short external pulse ends before the sample
    @(negedge clk);
    extHold = 1'b1;
    measure(3, hi, pd);
    chk(pd == DRV, "R8 short pulse pull-down", pd, DRV);
    chk(hi == 2 * SYN + 1 + DRV + SMP, "R8 short pulse sequence", hi, 2 * SYN + 1 + DRV + SMP);
    chk(int'(vecSel) == 0, "R8 short pulse vector", vecSel, 0);
    checkIdle("R8 idle after short pulse");

    // R9: clock-loss request arrives during the wait phase of a watchdog reset
    @(negedge clk);
    copReq = 1'b1;
    repeat (2) @(negedge clk);
    copReq = 1'b0;
    repeat (DRV + 3) @(negedge clk);
    #1;
    chk(pinPullDown == 1'b0 && sysReset == 1'b1, "R9 in wait phase", {sysReset, pinPullDown}, 2);
    cmonReq = 1'b1;
    #1;
    chk(pinPullDown == 1'b1, "R9 restart drives pin", pinPullDown, 1);
    repeat (2) @(negedge clk);
    cmonReq = 1'b0;
    measure(-1, hi, pd);
    chk(pd == DRV, "R9 restarted pull-down", pd, DRV);
    chk(hi == DRV + SMP + SYN, "R9 restarted release", hi, DRV + SMP + SYN);
    chk(int'(vecSel) == 1, "R9 kept causes vector", vecSel, 1);
    checkIdle("R9 idle after restart");

    // R10: nothing moves the vector while out of reset
    repeat (20) @(negedge clk);
    #1;
    chk(int'(vecSel) == 1 && !sysReset, "R10 vector held out of reset", vecSel, 1);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      nChk++;
      nFail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end
endmodule